// File: doc/BRIEF.md
# Interrupt Controller Register Interface

This block is the programmable register side of an eight-input interrupt controller. A host reaches it through a small byte-wide bus with one address bit. Address 0 is the command port and address 1 is the data port, and there are separate write and read strobes. The host first runs a multi-word initialization sequence: a configuration word, a vector base word, an optional cascade word and an optional mode word. After that it uses command words to acknowledge interrupts and to choose what a command-port read returns. Data-port writes made outside initialization load the interrupt mask.

The block holds the mask, the in-service register, the vector base, the cascade word and the automatic end-of-interrupt flag, and it drives all of them to a separate arbitration stage. That stage picks the winning request and asks this block to mark it in service through a set-request input. Request detection, prioritisation and vector delivery are outside this block.

Top module: `intc_regs`

## Requirements
- R1: A command write with bit 4 set starts initialization, and restarts it when one is already running. It captures configuration bit 1 (single mode when 1) and bit 0 (mode word wanted when 1), and the next data write is taken as the vector base word. `initBusy` is 1 from the cycle after that write until the sequence ends.
- R2: The first data write after an initialization start loads `vectorBase` with bits 7:3 of the written byte, and bits 2:0 read as zero.
- R3: When the configuration has bit 1 = 1 and bit 0 = 0, initialization ends on the vector base word.
- R4: When configuration bit 1 = 0, the data write after the vector base word loads `cascadeOut`. Initialization ends there if configuration bit 0 = 0, and otherwise a mode word follows.
- R5: The mode word (the next data write whenever configuration bit 0 = 1) sets `autoEoi` when its bit 1 is 1. Its other bits have no effect, `autoEoi` stays set until reset, and the word ends initialization.
- R6: A data write while `initBusy` is 0 loads `maskOut`. A data write during initialization leaves the mask unchanged. A data-port read returns the mask on `rdData` in the same cycle.
- R7: A command write of exactly 0x0B arms a one-shot flag. The next command-port read returns the in-service register and clears the flag. A command-port read with the flag clear returns 0. Any other command write with bit 4 = 0 and bit 3 = 1 has no effect.
- R8: A command write with bit 4 = 0 and bit 3 = 0 is an acknowledge word. If bit 5 is 1 and bit 6 is 1, it clears the in-service bit selected by bits 2:0. If bit 5 is 1 and bit 6 is 0, it clears the whole in-service register. If bit 5 is 0, it has no effect.
- R9: A synchronous active-low reset clears the mask, in-service, vector base, cascade, automatic end-of-interrupt and read flag, and it leaves `initBusy` at 0.
- R10: `isrSetValid` sets in-service bit `isrSetIdx` at the next edge. When it arrives in the same cycle as an acknowledge clear, the clear is applied first and the set second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| addrSel | input | 1 | 0 = command port, 1 = data port |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the read cycle |
| isrSetValid | input | 1 | Request from the arbitration stage to mark a line in service |
| isrSetIdx | input | 3 | Line to mark in service |
| maskOut | output | 8 | Interrupt mask register |
| inServiceOut | output | 8 | In-service register |
| vectorBase | output | 8 | Vector base, bits 2:0 zero |
| cascadeOut | output | 8 | Cascade configuration word |
| autoEoi | output | 1 | Automatic end-of-interrupt mode |
| initBusy | output | 1 | Initialization sequence in progress |

## Verification
The hardest cases to reach from the ports are the ones that depend on history. An acknowledge clear and a set request can land on the same in-service bit in one cycle. A new initialization start can arrive while an earlier sequence is only half done. The stimulus first builds a known in-service pattern with set requests. It then issues a specific acknowledge and a new set request for the same line together, and a clear-all together with a set request. It also breaks off a cascade-mode sequence after its vector base word with a fresh single-mode start. A behavioural model in the bench follows every cycle, so each of these is checked on every register at once.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BUS_W = 8;
  localparam int NUM_IRQ = 8;
  localparam int IDX_W = $clog2(NUM_IRQ);

  // command and configuration field positions
  localparam int CMD_INIT_BIT   = 4;
  localparam int CMD_OCW3_BIT   = 3;
  localparam int ACK_EOI_BIT    = 5;
  localparam int ACK_SPEC_BIT   = 6;
  localparam int CFG_FOURTH_BIT = 0;
  localparam int CFG_SINGLE_BIT = 1;
  localparam int MODE_AEOI_BIT  = 1;
  localparam logic [BUS_W-1:0] READ_ISR_CODE = 8'h0B;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_BASE,
    PH_CASC,
    PH_MODE
  } initPhase_t;

  typedef struct packed {
    logic loadCfg;
    logic loadBase;
    logic loadCasc;
    logic loadMask;
    logic setAeoi;
    logic armIsrRead;
    logic dropIsrRead;
    logic eoiAll;
    logic eoiOne;
  } strobes_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [BUS_W-1:0] wrData,
  input  logic             cfgSingle,
  input  logic             cfgFourth,
  input  logic             isrReadArmed,
  output strobes_t         strobe,
  output logic             initBusy
);
  initPhase_t phase, phaseNext;
  logic cmdWr, dataWr, isInit, isOcw3, isAck;

  always_comb begin
    cmdWr  = wrEn && !addrSel;
    dataWr = wrEn && addrSel;
    isInit = cmdWr && wrData[CMD_INIT_BIT];
    isOcw3 = cmdWr && !wrData[CMD_INIT_BIT] && wrData[CMD_OCW3_BIT];
    isAck  = cmdWr && !wrData[CMD_INIT_BIT] && !wrData[CMD_OCW3_BIT];
  end

  always_comb begin
    strobe             = '0;
    phaseNext          = phase;
    strobe.loadCfg     = isInit;
    strobe.armIsrRead  = isOcw3 && (wrData == READ_ISR_CODE);
    strobe.dropIsrRead = rdEn && !addrSel && isrReadArmed;
    strobe.eoiAll      = isAck && wrData[ACK_EOI_BIT] && !wrData[ACK_SPEC_BIT];
    strobe.eoiOne      = isAck && wrData[ACK_EOI_BIT] && wrData[ACK_SPEC_BIT];
    if (isInit) begin
      phaseNext = PH_BASE;
    end else if (dataWr) begin
      case (phase)
        PH_IDLE: strobe.loadMask = 1'b1;
        PH_BASE: begin
          strobe.loadBase = 1'b1;
          if (cfgSingle && !cfgFourth) phaseNext = PH_IDLE;
          else if (!cfgSingle)         phaseNext = PH_CASC;
          else                         phaseNext = PH_MODE;
        end
        PH_CASC: begin
          strobe.loadCasc = 1'b1;
          phaseNext = cfgFourth ? PH_MODE : PH_IDLE;
        end
        PH_MODE: begin
          strobe.setAeoi = wrData[MODE_AEOI_BIT];
          phaseNext = PH_IDLE;
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign initBusy = (phase != PH_IDLE);
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrSel,
  input  logic [BUS_W-1:0]   wrData,
  input  strobes_t           strobe,
  input  logic               isrSetValid,
  input  logic [IDX_W-1:0]   isrSetIdx,
  output logic [BUS_W-1:0]   rdData,
  output logic [NUM_IRQ-1:0] maskReg,
  output logic [NUM_IRQ-1:0] isrReg,
  output logic [BUS_W-1:0]   baseReg,
  output logic [BUS_W-1:0]   cascReg,
  output logic               aeoiReg,
  output logic               cfgSingle,
  output logic               cfgFourth,
  output logic               isrReadArmed
);
  logic [NUM_IRQ-1:0] isrNext;

  // clear first, then set: a same-cycle request survives the acknowledge
  always_comb begin
    isrNext = isrReg;
    if (strobe.eoiAll) isrNext = '0;
    if (strobe.eoiOne) isrNext[wrData[IDX_W-1:0]] = 1'b0;
    if (isrSetValid)   isrNext[isrSetIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg      <= '0;
      isrReg       <= '0;
      baseReg      <= '0;
      cascReg      <= '0;
      aeoiReg      <= 1'b0;
      cfgSingle    <= 1'b0;
      cfgFourth    <= 1'b0;
      isrReadArmed <= 1'b0;
    end else begin
      isrReg <= isrNext;
      if (strobe.loadCfg) begin
        cfgSingle <= wrData[CFG_SINGLE_BIT];
        cfgFourth <= wrData[CFG_FOURTH_BIT];
      end
      if (strobe.loadMask) maskReg <= wrData[NUM_IRQ-1:0];
      if (strobe.loadBase) baseReg <= {wrData[BUS_W-1:IDX_W], {IDX_W{1'b0}}};
      if (strobe.loadCasc) cascReg <= wrData;
      if (strobe.setAeoi)  aeoiReg <= 1'b1;
      if (strobe.armIsrRead)       isrReadArmed <= 1'b1;
      else if (strobe.dropIsrRead) isrReadArmed <= 1'b0;
    end
  end

  always_comb begin
    if (addrSel)           rdData = BUS_W'(maskReg);
    else if (isrReadArmed) rdData = BUS_W'(isrReg);
    else                   rdData = '0;
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               addrSel,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   rdData,
  input  logic               isrSetValid,
  input  logic [IDX_W-1:0]   isrSetIdx,
  output logic [NUM_IRQ-1:0] maskOut,
  output logic [NUM_IRQ-1:0] inServiceOut,
  output logic [BUS_W-1:0]   vectorBase,
  output logic [BUS_W-1:0]   cascadeOut,
  output logic               autoEoi,
  output logic               initBusy
);
  strobes_t strobe;
  logic cfgSingle, cfgFourth, isrReadArmed;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .cfgSingle(cfgSingle), .cfgFourth(cfgFourth),
    .isrReadArmed(isrReadArmed), .strobe(strobe), .initBusy(initBusy)
  );

  intc_datapath u_dp (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrData(wrData),
    .strobe(strobe), .isrSetValid(isrSetValid), .isrSetIdx(isrSetIdx),
    .rdData(rdData), .maskReg(maskOut), .isrReg(inServiceOut),
    .baseReg(vectorBase), .cascReg(cascadeOut), .aeoiReg(autoEoi),
    .cfgSingle(cfgSingle), .cfgFourth(cfgFourth), .isrReadArmed(isrReadArmed)
  );
endmodule

// File: rtl/intc_regs_chk.sv
module intc_regs_chk
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               addrSel,
  input logic               wrEn,
  input logic               rdEn,
  input logic [BUS_W-1:0]   wrData,
  input logic [BUS_W-1:0]   rdData,
  input logic               isrSetValid,
  input logic [IDX_W-1:0]   isrSetIdx,
  input logic [NUM_IRQ-1:0] maskOut,
  input logic [NUM_IRQ-1:0] inServiceOut,
  input logic [BUS_W-1:0]   vectorBase,
  input logic               initBusy
);
  p_init_start_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[CMD_INIT_BIT]) |=> initBusy);

  p_base_aligned_r2: assert property (@(posedge clk) disable iff (!rstN)
    vectorBase[IDX_W-1:0] == '0);

  p_mask_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrSel && !initBusy) |=> maskOut == $past(wrData[NUM_IRQ-1:0]));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrSel && initBusy) |=> $stable(maskOut));

  p_data_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addrSel) |-> rdData == BUS_W'(maskOut));

  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !addrSel && !wrEn) |=> (!(rdEn && !addrSel) || rdData == '0));

  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !addrSel && wrData[7:3] == 5'b00100 && !isrSetValid)
      |=> inServiceOut == '0);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    isrSetValid |=> inServiceOut[$past(isrSetIdx)]);

  p_reset_r9: assert property (@(posedge clk)
    !rstN |=> (!initBusy && maskOut == '0 && inServiceOut == '0));
endmodule

bind intc_regs intc_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .rdEn(rdEn),
  .wrData(wrData), .rdData(rdData), .isrSetValid(isrSetValid),
  .isrSetIdx(isrSetIdx), .maskOut(maskOut), .inServiceOut(inServiceOut),
  .vectorBase(vectorBase), .initBusy(initBusy)
);

// File: tb/intc_regs_test.sv
`timescale 1ns/100ps
module intc_regs_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrSel = 1'b0, wrEn = 1'b0, rdEn = 1'b0, isrSetValid = 1'b0;
  logic [7:0] wrData = '0;
  logic [2:0] isrSetIdx = '0;
  logic [7:0] rdData, maskOut, inServiceOut, vectorBase, cascadeOut;
  logic autoEoi, initBusy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference state
  int mMask = 0, mIsr = 0, mBase = 0, mCasc = 0, mAeoi = 0, mArm = 0;
  int mPhase = 0, mCfg = 0;

  intc_regs uut (
    .clk(clk), .rstN(rstN), .addrSel(addrSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .isrSetValid(isrSetValid),
    .isrSetIdx(isrSetIdx), .maskOut(maskOut), .inServiceOut(inServiceOut),
    .vectorBase(vectorBase), .cascadeOut(cascadeOut), .autoEoi(autoEoi),
    .initBusy(initBusy)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, one step per edge
  always @(posedge clk) begin
    int nIsr;
    if (!rstN) begin
      mMask = 0; mIsr = 0; mBase = 0; mCasc = 0; mAeoi = 0; mArm = 0;
      mPhase = 0; mCfg = 0;
    end else begin
      nIsr = mIsr;
      if (wrEn && !addrSel) begin
        if (wrData[4]) begin
          mCfg = wrData; mPhase = 1;
        end else if (wrData[3]) begin
          if (wrData == 8'h0B) mArm = 1;
        end else if (wrData[5]) begin
          if (wrData[6]) nIsr = nIsr & ~(1 << wrData[2:0]);
          else nIsr = 0;
        end
      end
      if (wrEn && addrSel) begin
        case (mPhase)
          0: mMask = wrData;
          1: begin
            mBase = wrData & 8'hF8;
            if (mCfg[1] && !mCfg[0]) mPhase = 0;
            else if (!mCfg[1]) mPhase = 2;
            else mPhase = 3;
          end
          2: begin mCasc = wrData; mPhase = mCfg[0] ? 3 : 0; end
          default: begin if (wrData[1]) mAeoi = 1; mPhase = 0; end
        endcase
      end
      if (rdEn && !addrSel && !wrEn) mArm = 0;
      if (isrSetValid) nIsr = nIsr | (1 << isrSetIdx);
      mIsr = nIsr;
    end
  end

  // compare every register on every cycle
  always @(negedge clk) begin
    if (!finished) begin
      chk("R6 mask", maskOut, mMask);
      chk("R8 in-service", inServiceOut, mIsr);
      chk("R2 vector base", vectorBase, mBase);
      chk("R4 cascade", cascadeOut, mCasc);
      chk("R5 autoEoi", autoEoi, mAeoi);
      chk("R1 initBusy", initBusy, (mPhase != 0) ? 1 : 0);
      if (rdEn) chk("R7 read data", rdData, addrSel ? mMask : (mArm ? mIsr : 0));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    wrEn = 0; rdEn = 0; isrSetValid = 0;
  endtask
  task automatic wrCmd(input logic [7:0] v);
    addrSel = 0; wrEn = 1; wrData = v; tick();
  endtask
  task automatic wrDat(input logic [7:0] v);
    addrSel = 1; wrEn = 1; wrData = v; tick();
  endtask
  task automatic rdCmd(input string tag, input int exp);
    addrSel = 0; rdEn = 1; #1; chk(tag, rdData, exp); tick();
  endtask
  task automatic setReq(input logic [2:0] i);
    isrSetValid = 1; isrSetIdx = i; tick();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    chk("R9 reset busy", initBusy, 0);
    chk("R9 reset mask", maskOut, 0);
    // R6 mask outside init
    wrDat(8'hA5);
    chk("R6 mask load", maskOut, 8'hA5);
    // single mode with mode word
    wrCmd(8'h13);
    chk("R1 busy after start", initBusy, 1);
    wrDat(8'h47);
    chk("R2 base low bits zero", vectorBase, 8'h40);
    chk("R6 mask held in init", maskOut, 8'hA5);
    wrDat(8'hFE);
    chk("R5 autoEoi set", autoEoi, 1);
    chk("R5 init ended", initBusy, 0);
    // R3 single without mode word
    wrCmd(8'h12);
    wrDat(8'h29);
    chk("R3 ends after base", initBusy, 0);
    wrDat(8'h3C);
    chk("R6 mask after R3 sequence", maskOut, 8'h3C);
    // cascade with mode word; bit1 clear leaves sticky autoEoi
    wrCmd(8'h11);
    wrDat(8'h88);
    wrDat(8'h04);
    chk("R4 cascade stored", cascadeOut, 8'h04);
    chk("R4 mode word pending", initBusy, 1);
    wrDat(8'h01);
    chk("R5 sticky autoEoi", autoEoi, 1);
    // cascade without mode word
    wrCmd(8'h10);
    wrDat(8'hF7);
    wrDat(8'h02);
    chk("R4 ends after cascade", initBusy, 0);
    // R1 restart mid-sequence
    wrCmd(8'h11);
    wrDat(8'h50);
    wrCmd(8'h12);
    wrDat(8'h18);
    chk("R1 restart base", vectorBase, 8'h18);
    chk("R1 restart ended", initBusy, 0);
    // R10 set requests
    setReq(3'd0); setReq(3'd3); setReq(3'd7);
    chk("R10 set pattern", inServiceOut, 8'h89);
    // R7 read flag
    rdCmd("R7 unarmed read", 0);
    wrCmd(8'h0A);
    rdCmd("R7 other OCW3 ignored", 0);
    wrCmd(8'h0B);
    rdCmd("R7 armed read", 8'h89);
    rdCmd("R7 one shot", 0);
    // R8 acknowledges
    wrCmd(8'h63);
    chk("R8 specific clear", inServiceOut, 8'h81);
    wrCmd(8'h47);
    chk("R8 no EOI bit", inServiceOut, 8'h81);
    wrCmd(8'h20);
    chk("R8 clear all", inServiceOut, 8'h00);
    // R10 same-cycle set with clear
    setReq(3'd5); setReq(3'd1);
    addrSel = 0; wrEn = 1; wrData = 8'h65; isrSetValid = 1; isrSetIdx = 3'd5; tick();
    chk("R10 set after specific clear", inServiceOut, 8'h22);
    addrSel = 0; wrEn = 1; wrData = 8'h20; isrSetValid = 1; isrSetIdx = 3'd2; tick();
    chk("R10 set after clear all", inServiceOut, 8'h04);
    // R9 reset in mid-initialization
    wrCmd(8'h11);
    rstN = 0; tick(); #1 rstN = 1;
    chk("R9 busy cleared", initBusy, 0);
    chk("R9 isr cleared", inServiceOut, 0);
    chk("R9 aeoi cleared", autoEoi, 0);
    chk("R9 cascade cleared", cascadeOut, 0);
    wrDat(8'h5A);
    chk("R9 mask writable after reset", maskOut, 8'h5A);
    repeat (2) tick();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule